// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block decides, cycle by cycle, which parts of a small 8-bit microcontroller receive a clock. Software sets it up through two byte-wide special-function registers on a simple read/write bus. The mode register selects one of four global states: run, idle, sleep or power-down. It also stores a baud-doubling bit and two general-purpose flags, which the block only exports, and a handshake flag that guards watchdog reloads. The gate register holds one disable bit for each peripheral. The block combines the selected mode with the disable bits and drives one clock-enable output for the CPU core and one for each of Timer0/1, UART, watchdog, PWM, watch timer and LCD.

Idle stops only the core. Sleep also stops the general peripherals but keeps the watch timer and the LCD clocked unless their own disable bits are set. Power-down stops every clock. An enabled interrupt (`wake_irq`) or reset returns the block to run. A watchdog reload request is accepted only while the handshake flag is set. The block clears the flag when a reload is accepted. A request made while the flag is clear is refused and raises a one-cycle error pulse.

All register state updates on the rising clock edge. Reads and the clock-enable outputs are combinational from the stored state. A write is therefore visible on the read data and the enables directly after the edge that takes it. The control pins carry no flow control: a write is taken on every cycle in which `sfr_wr` is high, and no back-pressure applies.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the mode register (address 0x87) reads 0x00, the gate register (address 0xF1) reads 0x04, and all seven clock enables are 1.
- R2: The mode register has this layout: bit7 baud double, bit6 always reads 0, bit5 sleep, bit4 reload-enable flag, bit3 general flag 1, bit2 general flag 0, bit1 power-down, bit0 idle. `baud_double` and `gp_flags` ({bit3,bit2}) follow the stored bits.
- R3: The gate register has this layout: bit6 timer, bit5 UART, bit4 watchdog, bit3 PWM, bit1 watch timer, bit0 LCD, each 1 = disabled. Bit2 always reads 1 and bit7 always reads 0, whatever value is written.
- R4: In run mode (no mode bit set) the core enable is 1 and each peripheral enable is the inverse of its disable bit.
- R5: In idle mode the core enable is 0 and each peripheral enable is the inverse of its disable bit.
- R6: In sleep mode the core, timer, UART, watchdog and PWM enables are 0. The watch-timer and LCD enables are the inverse of their disable bits.
- R7: In power-down mode all seven enables are 0.
- R8: When a write to the mode register sets more than one mode bit, only the highest-priority bit is kept (power-down, then sleep, then idle), and only that bit reads back as 1.
- R9: A high `wake_irq` at a clock edge clears the idle, sleep and power-down bits. The other mode-register bits are kept. Wake takes precedence over a write in the same cycle.
- R10: A `wdt_load_req` made while the reload-enable flag is 1 gives a one-cycle `wdt_load_ack` pulse in the next cycle and clears the flag.
- R11: A `wdt_load_req` made while the reload-enable flag is 0 gives no acknowledge and gives a one-cycle `wdt_load_err` pulse in the next cycle.
- R12: Any other address reads 0x00, and writes to it leave both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_addr | input | 8 | Register address |
| sfr_wr | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for `sfr_addr` |
| wake_irq | input | 1 | Enabled interrupt; ends idle, sleep and power-down |
| wdt_load_req | input | 1 | Watchdog reload request |
| wdt_load_ack | output | 1 | Reload accepted (one-cycle pulse) |
| wdt_load_err | output | 1 | Reload refused (one-cycle pulse) |
| baud_double | output | 1 | Stored baud-doubling bit |
| gp_flags | output | 2 | Stored general-purpose flags |
| ce_cpu | output | 1 | CPU core clock enable |
| ce_timer | output | 1 | Timer0/1 clock enable |
| ce_uart | output | 1 | UART clock enable |
| ce_wdt | output | 1 | Watchdog clock enable |
| ce_pwm | output | 1 | PWM clock enable |
| ce_wtmr | output | 1 | Watch timer clock enable |
| ce_lcd | output | 1 | LCD clock enable |

## Verification
The bench drives every mode against all 64 combinations of the six disable bits. A design that let sleep override the LCD or watch-timer disable bit, or that left a peripheral running in power-down, shows a wrong enable vector there. Writes with several mode bits set check the priority order. A design that latched the bits as written reads back more than one mode bit and gates by the wrong mode. The reload checks cover the flag clearing after a load, the refused load, and the length of each pulse. The reserved gate bit is written both as 0 and as 1, which catches a register that stores that bit literally.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int NPERIPH = 6;

  localparam logic [AW-1:0] MODE_ADDR = 8'h87;
  localparam logic [AW-1:0] GATE_ADDR = 8'hF1;

  // mode register bit positions
  localparam int MB_BAUD = 7;
  localparam int MB_SLP  = 5;
  localparam int MB_WLE  = 4;
  localparam int MB_GF1  = 3;
  localparam int MB_GF0  = 2;
  localparam int MB_PD   = 1;
  localparam int MB_IDL  = 0;

  // gate register: reset value, forced-one bit, writable mask
  localparam logic [DW-1:0] GATE_RST   = 8'h04;
  localparam int            GATE_RSVD  = 2;
  localparam logic [DW-1:0] GATE_WMASK = 8'h7B;

  // peripheral index: 0 timer, 1 uart, 2 wdt, 3 pwm, 4 watch timer, 5 lcd
  localparam logic [NPERIPH-1:0] SLEEP_KEEP = 6'b110000;

  typedef enum logic [1:0] {PM_RUN, PM_IDLE, PM_SLEEP, PM_DOWN} pmode_e;

  function automatic int dis_bit(input int p);
    case (p)
      0: return 6;
      1: return 5;
      2: return 4;
      3: return 3;
      4: return 1;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/pwr_sfr_regs.sv
module pwr_sfr_regs
  import pwr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      sfr_addr,
  input  logic               sfr_wr,
  input  logic [DW-1:0]      sfr_wdata,
  output logic [DW-1:0]      sfr_rdata,
  input  logic               wake_irq,
  input  logic               wdt_load_req,
  output logic               wdt_load_ack,
  output logic               wdt_load_err,
  output pmode_e             mode,
  output logic               baud_double,
  output logic [1:0]         gp_flags,
  output logic [NPERIPH-1:0] periph_dis
);
  pmode_e          mode_q, mode_d;
  logic            baud_q, wle_q, wle_d;
  logic [1:0]      gpf_q;
  logic [DW-1:0]   gate_q;
  logic            wr_mode, wr_gate;
  logic [DW-1:0]   mode_rd;

  assign wr_mode = sfr_wr && (sfr_addr == MODE_ADDR);
  assign wr_gate = sfr_wr && (sfr_addr == GATE_ADDR);

  always_comb begin
    mode_d = mode_q;
    if (wr_mode) begin
      if (sfr_wdata[MB_PD])       mode_d = PM_DOWN;
      else if (sfr_wdata[MB_SLP]) mode_d = PM_SLEEP;
      else if (sfr_wdata[MB_IDL]) mode_d = PM_IDLE;
      else                        mode_d = PM_RUN;
    end
    if (wake_irq) mode_d = PM_RUN;
  end

  always_comb begin
    wle_d = wr_mode ? sfr_wdata[MB_WLE] : wle_q;
    if (wdt_load_req && wle_q) wle_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= PM_RUN;
      baud_q       <= 1'b0;
      wle_q        <= 1'b0;
      gpf_q        <= 2'b00;
      gate_q       <= GATE_RST;
      wdt_load_ack <= 1'b0;
      wdt_load_err <= 1'b0;
    end else begin
      mode_q       <= mode_d;
      wle_q        <= wle_d;
      wdt_load_ack <= wdt_load_req && wle_q;
      wdt_load_err <= wdt_load_req && !wle_q;
      if (wr_mode) begin
        baud_q <= sfr_wdata[MB_BAUD];
        gpf_q  <= {sfr_wdata[MB_GF1], sfr_wdata[MB_GF0]};
      end
      if (wr_gate) gate_q <= (sfr_wdata & GATE_WMASK) | GATE_RST;
    end
  end

  always_comb begin
    mode_rd          = '0;
    mode_rd[MB_BAUD] = baud_q;
    mode_rd[MB_SLP]  = (mode_q == PM_SLEEP);
    mode_rd[MB_WLE]  = wle_q;
    mode_rd[MB_GF1]  = gpf_q[1];
    mode_rd[MB_GF0]  = gpf_q[0];
    mode_rd[MB_PD]   = (mode_q == PM_DOWN);
    mode_rd[MB_IDL]  = (mode_q == PM_IDLE);
  end

  always_comb begin
    case (sfr_addr)
      MODE_ADDR: sfr_rdata = mode_rd;
      GATE_ADDR: sfr_rdata = gate_q;
      default:   sfr_rdata = '0;
    endcase
  end

  for (genvar p = 0; p < NPERIPH; p++) begin : g_dis
    assign periph_dis[p] = gate_q[dis_bit(p)];
  end

  assign mode        = mode_q;
  assign baud_double = baud_q;
  assign gp_flags    = gpf_q;

  AST_WLE_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_load_req && wle_q) |=> (!wle_q && wdt_load_ack)); // R10
  AST_LOAD_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_load_req && !wle_q) |=> (wdt_load_err && !wdt_load_ack)); // R11
  AST_WAKE_TO_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |=> (mode_q == PM_RUN)); // R9
  AST_RSVD_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == GATE_ADDR) |-> (sfr_rdata[GATE_RSVD] && !sfr_rdata[DW-1])); // R3
  AST_ONE_MODE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_addr == MODE_ADDR) |-> $onehot0({sfr_rdata[MB_PD], sfr_rdata[MB_SLP], sfr_rdata[MB_IDL]})); // R8
endmodule

// File: rtl/pwr_clk_gate.sv
module pwr_clk_gate
  import pwr_pkg::*;
(
  input  pmode_e             mode,
  input  logic [NPERIPH-1:0] periph_dis,
  output logic               ce_core,
  output logic [NPERIPH-1:0] ce_periph
);
  logic awake;
  assign awake   = (mode == PM_RUN) || (mode == PM_IDLE);
  assign ce_core = (mode == PM_RUN);

  for (genvar p = 0; p < NPERIPH; p++) begin : g_ce
    logic mode_allows;
    if (SLEEP_KEEP[p]) begin : g_keep
      assign mode_allows = awake || (mode == PM_SLEEP);
    end else begin : g_stop
      assign mode_allows = awake;
    end
    assign ce_periph[p] = mode_allows && !periph_dis[p];
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    sfr_addr,
  input  logic          sfr_wr,
  input  logic [7:0]    sfr_wdata,
  output logic [7:0]    sfr_rdata,
  input  logic          wake_irq,
  input  logic          wdt_load_req,
  output logic          wdt_load_ack,
  output logic          wdt_load_err,
  output logic          baud_double,
  output logic [1:0]    gp_flags,
  output logic          ce_cpu,
  output logic          ce_timer,
  output logic          ce_uart,
  output logic          ce_wdt,
  output logic          ce_pwm,
  output logic          ce_wtmr,
  output logic          ce_lcd
);
  pmode_e             mode;
  logic [NPERIPH-1:0] periph_dis;
  logic [NPERIPH-1:0] ce_periph;

  pwr_sfr_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .sfr_addr     (sfr_addr),
    .sfr_wr       (sfr_wr),
    .sfr_wdata    (sfr_wdata),
    .sfr_rdata    (sfr_rdata),
    .wake_irq     (wake_irq),
    .wdt_load_req (wdt_load_req),
    .wdt_load_ack (wdt_load_ack),
    .wdt_load_err (wdt_load_err),
    .mode         (mode),
    .baud_double  (baud_double),
    .gp_flags     (gp_flags),
    .periph_dis   (periph_dis)
  );

  pwr_clk_gate u_gate (
    .mode       (mode),
    .periph_dis (periph_dis),
    .ce_core    (ce_cpu),
    .ce_periph  (ce_periph)
  );

  assign ce_timer = ce_periph[0];
  assign ce_uart  = ce_periph[1];
  assign ce_wdt   = ce_periph[2];
  assign ce_pwm   = ce_periph[3];
  assign ce_wtmr  = ce_periph[4];
  assign ce_lcd   = ce_periph[5];

  AST_DOWN_ALL_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_DOWN) |-> !(ce_cpu || (|ce_periph))); // R7
  AST_SLEEP_ONLY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_SLEEP) |-> (!ce_cpu && ((ce_periph & ~SLEEP_KEEP) == '0))); // R6
  AST_DISABLED_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_periph & periph_dis) == '0); // R4
  AST_IDLE_CORE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_IDLE) |-> (!ce_cpu && (ce_periph == ~periph_dis))); // R5
endmodule

// File: tb/pwr_mode_ctrl_tb.sv
module pwr_mode_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic       wake_irq = 1'b0;
  logic       wdt_load_req = 1'b0;
  logic       wdt_load_ack, wdt_load_err, baud_double;
  logic [1:0] gp_flags;
  logic       ce_cpu, ce_timer, ce_uart, ce_wdt, ce_pwm, ce_wtmr, ce_lcd;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pwr_mode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .wake_irq(wake_irq),
    .wdt_load_req(wdt_load_req), .wdt_load_ack(wdt_load_ack),
    .wdt_load_err(wdt_load_err), .baud_double(baud_double), .gp_flags(gp_flags),
    .ce_cpu(ce_cpu), .ce_timer(ce_timer), .ce_uart(ce_uart), .ce_wdt(ce_wdt),
    .ce_pwm(ce_pwm), .ce_wtmr(ce_wtmr), .ce_lcd(ce_lcd)
  );

  localparam logic [7:0] A_MODE = 8'h87;
  localparam logic [7:0] A_GATE = 8'hF1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0;
  endtask

  task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
    sfr_addr = a;
    #0.5;
    d = sfr_rdata;
  endtask

  function automatic logic [6:0] ces();
    return {ce_cpu, ce_timer, ce_uart, ce_wdt, ce_pwm, ce_wtmr, ce_lcd};
  endfunction

  // mode: 0 run, 1 idle, 2 sleep, 3 down; g = gate register value
  function automatic logic [6:0] exp_ce(input int m, input logic [7:0] g);
    logic [5:0] on;
    on = ~{g[6], g[5], g[4], g[3], g[1], g[0]};
    case (m)
      0: return {1'b1, on};
      1: return {1'b0, on};
      2: return {1'b0, 4'b0000, on[1:0]};
      default: return 7'b0;
    endcase
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    sfr_read(A_MODE, d); check("R1 mode reg after reset", d, 8'h00);
    sfr_read(A_GATE, d); check("R1 gate reg after reset", d, 8'h04);
    check("R1 enables after reset", ces(), 7'h7F);
  endtask

  task automatic t_layout();
    logic [7:0] d;
    sfr_write(A_MODE, 8'hCC);
    sfr_read(A_MODE, d); check("R2 mode read, bit6 zero", d, 8'h8C);
    check("R2 baud_double", baud_double, 1'b1);
    check("R2 gp_flags", gp_flags, 2'b11);
    sfr_write(A_MODE, 8'h08);
    check("R2 gp_flags after rewrite", gp_flags, 2'b10);
    check("R2 baud_double cleared", baud_double, 1'b0);
    sfr_write(A_MODE, 8'h00);
  endtask

  task automatic t_gate_rsvd();
    logic [7:0] d;
    sfr_write(A_GATE, 8'h00);
    sfr_read(A_GATE, d); check("R3 reserved bit forced one", d, 8'h04);
    sfr_write(A_GATE, 8'hFF);
    sfr_read(A_GATE, d); check("R3 bit7 reads zero", d, 8'h7F);
    sfr_write(A_GATE, 8'h04);
  endtask

  task automatic t_matrix();
    logic [7:0] mw [4];
    string      rq [4];
    mw[0] = 8'h00; mw[1] = 8'h01; mw[2] = 8'h20; mw[3] = 8'h02;
    rq[0] = "R4 run"; rq[1] = "R5 idle"; rq[2] = "R6 sleep"; rq[3] = "R7 down";
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 64; k++) begin
        logic [7:0] g;
        g = {1'b0, k[5], k[4], k[3], k[2], 1'b1, k[1], k[0]};
        sfr_write(A_GATE, g);
        sfr_write(A_MODE, mw[m]);
        check(rq[m], ces(), exp_ce(m, g));
      end
    end
    sfr_write(A_MODE, 8'h00);
    sfr_write(A_GATE, 8'h04);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    sfr_write(A_MODE, 8'h23);
    sfr_read(A_MODE, d); check("R8 pd over sleep and idle", d, 8'h02);
    check("R8 pd gating", ces(), 7'h00);
    sfr_write(A_MODE, 8'h21);
    sfr_read(A_MODE, d); check("R8 sleep over idle", d, 8'h20);
    check("R8 sleep gating", ces(), 7'h03);
    sfr_write(A_MODE, 8'h00);
  endtask

  task automatic t_wake();
    logic [7:0] d;
    sfr_write(A_MODE, 8'hBD);
    sfr_read(A_MODE, d); check("R8 sleep kept of mixed write", d, 8'hBC);
    @(negedge clk); wake_irq = 1'b1;
    @(negedge clk); wake_irq = 1'b0;
    sfr_read(A_MODE, d); check("R9 wake clears mode bits only", d, 8'h9C);
    check("R9 enables after wake", ces(), 7'h7F);
    // wake and a power-down write in the same cycle
    @(negedge clk);
    sfr_addr = A_MODE; sfr_wdata = 8'h02; sfr_wr = 1'b1; wake_irq = 1'b1;
    @(negedge clk);
    sfr_wr = 1'b0; wake_irq = 1'b0;
    sfr_read(A_MODE, d); check("R9 wake wins over write", d, 8'h00);
  endtask

  task automatic t_wdt_ok();
    logic [7:0] d;
    sfr_write(A_MODE, 8'h10);
    sfr_read(A_MODE, d); check("R10 flag set", d, 8'h10);
    @(negedge clk); wdt_load_req = 1'b1;
    @(negedge clk); wdt_load_req = 1'b0;
    check("R10 ack pulse", wdt_load_ack, 1'b1);
    check("R10 no err on accepted load", wdt_load_err, 1'b0);
    sfr_read(A_MODE, d); check("R10 flag cleared by load", d, 8'h00);
    @(negedge clk);
    check("R10 ack lasts one cycle", wdt_load_ack, 1'b0);
  endtask

  task automatic t_wdt_err();
    @(negedge clk); wdt_load_req = 1'b1;
    @(negedge clk); wdt_load_req = 1'b0;
    check("R11 err pulse", wdt_load_err, 1'b1);
    check("R11 load ignored", wdt_load_ack, 1'b0);
    @(negedge clk);
    check("R11 err lasts one cycle", wdt_load_err, 1'b0);
  endtask

  task automatic t_bad_addr();
    logic [7:0] d;
    sfr_write(A_GATE, 8'h09);
    sfr_write(8'h55, 8'hFF);
    sfr_read(8'h55, d); check("R12 unmapped reads zero", d, 8'h00);
    sfr_read(A_MODE, d); check("R12 mode reg untouched", d, 8'h00);
    sfr_read(A_GATE, d); check("R12 gate reg untouched", d, 8'h0D);
    sfr_write(A_GATE, 8'h04);
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_gate_rsvd();
    t_matrix();
    t_priority();
    t_wake();
    t_wdt_ok();
    t_wdt_err();
    t_bad_addr();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule